// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order processor with five stages: fetch, decode, execute, memory and writeback. Behind writeback sits one more latch that only feeds the bypass network. The core has eight 32-bit registers and two separate word-addressed memories, one for instructions and one for data. Both memories live outside the core and are read combinationally. The instruction set has eight opcodes: add, nand, load, store, branch-if-equal, jump-and-link, halt and no-op. Jump-and-link is decoded but has no effect.

Branches are resolved in the memory stage. A taken branch replaces the three younger latches with no-ops and redirects the program counter. Operands are bypassed from the three older latches, with the youngest producer taking priority. A load followed at once by a dependent instruction costs one bubble. When a halt reaches the memory/writeback latch, the core raises `halted` and freezes. The cycle counter then stops and shows how many clocks the program took.

Top module: `lc_pipe_core`

## Requirements
- R1: While reset is held, the program counter (`imem_addr`) is 0, `cycle_count` is 0 and `halted` is 0. All five pipeline latches hold the no-op word 0x01C00000 and all registers hold 0.
- R2: Instruction fields are: opcode in bits 24:22, first source in 21:19, second source in 18:16, offset in 15:0. The opcodes are add=0, nand=1, load=2, store=3, beq=4, jalr=5, halt=6, noop=7. Add writes the sum and nand writes the bitwise NAND of its two sources into the register named by bits 2:0.
- R3: Load and store address data memory at the first source plus the sign-extended 16-bit offset. Load writes the word it reads into the register in bits 18:16. Store writes that register's value to memory.
- R4: An operand is taken from the youngest older instruction that writes the same register. The order is the execute/memory latch (add or nand only), then memory/writeback, then the end latch, then the register file.
- R5: If a load in decode/execute writes a register that the instruction in fetch/decode reads as a source, fetch and the program counter hold for one cycle and a bubble enters execute. Add, nand and beq read both sources; load and store read only the first source for this check.
- R6: A beq whose sources are equal loads the program counter with its own address + 1 + sign-extended offset, and the three instructions fetched after it never take effect. A beq with unequal sources does not redirect.
- R7: `halted` rises in the cycle after the halt reaches the memory/writeback latch. From then on there are no further stores, and the counter and program counter no longer change.
- R8: `cycle_count` grows by one on each clock edge until halt. For a straight-line program with halt at address h, no stalls and no taken branches, it stops at h+4.
- R9: A store whose data register is written by a load one instruction ahead writes the loaded value.
- R10: jalr and noop change no register and no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | PCW | Instruction word address (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | PCW | Data word address for the instruction in the memory stage |
| dmem_rdata | input | DW | Data word at `dmem_addr`, combinational |
| dmem_we | output | 1 | Store strobe, written at the next rising edge |
| dmem_wdata | output | DW | Store data |
| halted | output | 1 | Halt has reached the memory/writeback latch |
| cycle_count | output | CNTW | Clock edges since reset, frozen at halt |

## Verification
A table of add and nand operand pairs is run through one fixed load, load, operate, store program. The pairs cover carry out, signed overflow, an all-zero nand and a cancelling sum, so a wrong ALU function or a missing load-use bubble shows up as a wrong stored word or a wrong cycle count. Directed programs then separate the bypass sources: the same register is live in two older stages at once, so only the youngest-wins order gives the right sum. A load followed by a store of the same register checks the memory-stage bypass, and a negative offset checks sign extension. A branch program places stores and a halt in the flush shadow, and follows with a jalr, a not-taken beq and a store after halt. This tells a correct flush and freeze apart from leaked side effects.

// File: rtl/lc_pipe_core.sv
module lc_pipe_core #(
  parameter int PCW  = 16,
  parameter int DW   = 32,
  parameter int CNTW = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PCW-1:0]  imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [PCW-1:0]  dmem_addr,
  input  logic [DW-1:0]   dmem_rdata,
  output logic            dmem_we,
  output logic [DW-1:0]   dmem_wdata,
  output logic            halted,
  output logic [CNTW-1:0] cycle_count
);
  localparam int NREG = 8;
  localparam logic [2:0] OP_ADD = 3'd0, OP_NAND = 3'd1, OP_LW = 3'd2, OP_SW = 3'd3,
                         OP_BEQ = 3'd4, OP_HALT = 3'd6, OP_NOOP = 3'd7;
  localparam logic [31:0] NOOP_W = 32'h01C0_0000;

  logic [PCW-1:0] pc, ifid_p1, idex_p1, exmem_tgt;
  logic [31:0]    ifid_i, idex_i, exmem_i, memwb_i, wbend_i;
  logic [DW-1:0]  idex_a, idex_b, idex_off, exmem_alu, exmem_b, memwb_d, wbend_d;
  logic [DW-1:0]  rf [NREG];

  function automatic logic [2:0] opc(input logic [31:0] i);
    return i[24:22];
  endfunction

  function automatic logic writes(input logic [31:0] i);
    return opc(i) == OP_ADD || opc(i) == OP_NAND || opc(i) == OP_LW;
  endfunction

  function automatic logic [2:0] dst(input logic [31:0] i);
    return (opc(i) == OP_LW) ? i[18:16] : i[2:0];
  endfunction

  function automatic logic [DW-1:0] fwd(input logic [2:0] r, input logic [DW-1:0] d);
    if ((opc(exmem_i) == OP_ADD || opc(exmem_i) == OP_NAND) && exmem_i[2:0] == r) return exmem_alu;
    if (writes(memwb_i) && dst(memwb_i) == r) return memwb_d;
    if (writes(wbend_i) && dst(wbend_i) == r) return wbend_d;
    return d;
  endfunction

  logic [2:0]    id_op, ex_op, mem_op, ld_dst;
  logic          stall, taken, ex_pass;
  logic [DW-1:0] op_a, op_b_reg, op_b, alu, sw_data;

  assign id_op  = opc(ifid_i);
  assign ex_op  = opc(idex_i);
  assign mem_op = opc(exmem_i);
  assign ld_dst = idex_i[18:16];

  always_comb begin
    stall = 1'b0;
    if (ex_op == OP_LW) begin
      if (id_op == OP_ADD || id_op == OP_NAND || id_op == OP_BEQ)
        stall = (ifid_i[21:19] == ld_dst) || (ifid_i[18:16] == ld_dst);
      else if (id_op == OP_LW || id_op == OP_SW)
        stall = (ifid_i[21:19] == ld_dst);
    end
  end

  assign ex_pass  = (ex_op == OP_HALT) || (ex_op == OP_NOOP);
  assign op_a     = ex_pass ? idex_a : fwd(idex_i[21:19], idex_a);
  assign op_b_reg = ex_pass ? idex_b : fwd(idex_i[18:16], idex_b);
  assign op_b     = (ex_op == OP_ADD || ex_op == OP_NAND || ex_op == OP_BEQ) ? op_b_reg : idex_off;

  always_comb begin
    if (ex_op == OP_NAND)     alu = ~(op_a & op_b);
    else if (ex_op == OP_BEQ) alu = {{(DW-1){1'b0}}, op_a == op_b};
    else                      alu = op_a + op_b;
  end

  assign sw_data = (opc(memwb_i) == OP_LW && memwb_i[18:16] == exmem_i[18:16]) ? memwb_d : exmem_b;
  assign taken   = (mem_op == OP_BEQ) && (exmem_alu != '0);

  assign halted     = (opc(memwb_i) == OP_HALT);
  assign imem_addr  = pc;
  assign dmem_addr  = exmem_alu[PCW-1:0];
  assign dmem_we    = (mem_op == OP_SW) && !halted;
  assign dmem_wdata = sw_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc          <= '0;
      cycle_count <= '0;
      ifid_i  <= NOOP_W; idex_i  <= NOOP_W; exmem_i <= NOOP_W;
      memwb_i <= NOOP_W; wbend_i <= NOOP_W;
      ifid_p1 <= '0; idex_p1 <= '0; exmem_tgt <= '0;
      idex_a <= '0; idex_b <= '0; idex_off <= '0;
      exmem_alu <= '0; exmem_b <= '0; memwb_d <= '0; wbend_d <= '0;
      for (int k = 0; k < NREG; k++) rf[k] <= '0;
    end else if (!halted) begin
      cycle_count <= cycle_count + 1'b1;
      if (!stall) begin
        ifid_i  <= imem_rdata;
        ifid_p1 <= pc + 1'b1;
        pc      <= pc + 1'b1;
      end
      idex_i   <= stall ? NOOP_W : ifid_i;
      idex_p1  <= ifid_p1;
      idex_a   <= rf[ifid_i[21:19]];
      idex_b   <= rf[ifid_i[18:16]];
      idex_off <= {{(DW-16){ifid_i[15]}}, ifid_i[15:0]};
      exmem_i   <= idex_i;
      exmem_tgt <= idex_p1 + idex_off[PCW-1:0];
      exmem_alu <= alu;
      exmem_b   <= op_b_reg;
      memwb_i <= exmem_i;
      memwb_d <= (mem_op == OP_LW || mem_op == OP_SW) ? dmem_rdata : exmem_alu;
      if (taken) begin
        pc      <= exmem_tgt;
        ifid_i  <= NOOP_W;
        idex_i  <= NOOP_W;
        exmem_i <= NOOP_W;
      end
      wbend_i <= memwb_i;
      wbend_d <= memwb_d;
      if (writes(memwb_i)) rf[dst(memwb_i)] <= memwb_d;
    end
  end

  // R6
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && taken) |=> (ifid_i == NOOP_W && idex_i == NOOP_W && exmem_i == NOOP_W));
  // R6
  redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && taken) |=> (imem_addr == $past(exmem_tgt)));
  // R5
  bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && stall && !taken) |=> (idex_i == NOOP_W && $stable(imem_addr) && $stable(ifid_i)));
  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(cycle_count) && $stable(imem_addr)));
  // R8
  count_chk: assert property (@(posedge clk) disable iff (rst)
    !halted |=> (cycle_count == $past(cycle_count) + 1'b1));
  // R4
  end_latch_chk: assert property (@(posedge clk) disable iff (rst)
    !halted |=> (wbend_i == $past(memwb_i) && wbend_d == $past(memwb_d)));
endmodule

// File: tb/lc_pipe_core_tb_top.sv
module lc_pipe_core_tb_top;
  localparam int PCW = 16, DW = 32, CNTW = 32, MW = 64;
  localparam logic [31:0] NOOP_W = 32'h01C0_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic [PCW-1:0]  imem_addr, dmem_addr;
  logic [31:0]     imem_rdata;
  logic [DW-1:0]   dmem_rdata, dmem_wdata;
  logic            dmem_we, halted;
  logic [CNTW-1:0] cycle_count;
  logic [31:0] imem [MW];
  logic [DW-1:0] dmem [MW];
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign imem_rdata = imem[imem_addr[5:0]];
  assign dmem_rdata = dmem[dmem_addr[5:0]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;

  lc_pipe_core #(.PCW(PCW), .DW(DW), .CNTW(CNTW)) dut_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .halted(halted), .cycle_count(cycle_count));

  function automatic logic [31:0] enc(input int op, input int a, input int b, input int off);
    return {7'b0, op[2:0], a[2:0], b[2:0], off[15:0]};
  endfunction

  // op, first operand, second operand, expected result
  localparam logic [98:0] VEC [6] = '{
    {3'd0, 32'd5,        32'd7,        32'd12},
    {3'd0, 32'hFFFFFFFF, 32'd1,        32'd0},
    {3'd1, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FFF0FFF},
    {3'd0, 32'h7FFFFFFF, 32'd1,        32'h80000000},
    {3'd1, 32'd0,        32'd0,        32'hFFFFFFFF},
    {3'd0, 32'hFFFFFFFD, 32'd3,        32'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mems();
    for (int k = 0; k < MW; k++) begin
      imem[k] = NOOP_W;
      dmem[k] = '0;
    end
  endtask

  task automatic run_prog();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", 32'(imem_addr), 32'd0);
    chk("R1 reset count", cycle_count, 32'd0);
    chk("R1 reset halted", 32'(halted), 32'd0);
    rst = 1'b0;
    for (int n = 0; n < 400 && !halted; n++) @(negedge clk);
    chk("R7 halt reached", 32'(halted), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R7 watchdog expired actual=running expected=halted");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R2 R5 R8: table of ALU cases through load, load, operate, store
    for (int v = 0; v < 6; v++) begin
      clear_mems();
      imem[0] = enc(2, 0, 1, 0);
      imem[1] = enc(2, 0, 2, 1);
      imem[2] = enc(int'(VEC[v][98:96]), 1, 2, 3);
      imem[3] = enc(3, 0, 3, 2);
      imem[4] = enc(6, 0, 0, 0);
      dmem[0] = VEC[v][95:64];
      dmem[1] = VEC[v][63:32];
      run_prog();
      chk("R2 alu result", dmem[2], VEC[v][31:0]);
      chk("R5 R8 cycles with one bubble", cycle_count, 32'd9);
    end

    // R4: bypass priority across three older stages
    clear_mems();
    imem[0] = enc(2, 0, 1, 0);
    imem[1] = enc(2, 0, 2, 1);
    imem[3] = enc(0, 1, 1, 3);
    imem[4] = enc(0, 3, 2, 3);
    imem[5] = enc(0, 3, 1, 3);
    imem[7] = enc(3, 0, 3, 4);
    imem[8] = enc(3, 0, 3, 5);
    imem[9] = enc(6, 0, 0, 0);
    dmem[0] = 32'd10;
    dmem[1] = 32'd20;
    run_prog();
    chk("R4 youngest wins, via mem/wb", dmem[4], 32'd50);
    chk("R4 via end latch", dmem[5], 32'd50);
    chk("R8 straight-line cycles", cycle_count, 32'd13);

    // R3 R9: load-to-store bypass and negative offsets
    clear_mems();
    imem[0] = enc(2, 0, 1, 0);
    imem[1] = enc(3, 0, 1, 3);
    imem[2] = enc(2, 0, 4, 1);
    imem[3] = enc(2, 4, 5, -10);
    imem[4] = enc(3, 4, 5, -4);
    imem[5] = enc(6, 0, 0, 0);
    dmem[0] = 32'h1234;
    dmem[1] = 32'd12;
    dmem[2] = 32'd77;
    run_prog();
    chk("R9 store of just-loaded reg", dmem[3], 32'h1234);
    chk("R3 negative offsets", dmem[8], 32'd77);
    chk("R5 R8 cycles", cycle_count, 32'd10);

    // R6 R10 R7: taken branch shadow, jalr, not-taken beq, store after halt
    clear_mems();
    imem[0]  = enc(2, 0, 1, 0);
    imem[1]  = enc(2, 0, 2, 1);
    imem[2]  = enc(4, 1, 2, 3);
    imem[3]  = enc(3, 0, 1, 10);
    imem[4]  = enc(3, 0, 1, 11);
    imem[5]  = enc(6, 0, 0, 0);
    imem[6]  = enc(5, 1, 2, 0);
    imem[7]  = enc(4, 0, 1, 5);
    imem[8]  = enc(3, 0, 1, 12);
    imem[9]  = enc(3, 0, 2, 13);
    imem[10] = enc(6, 0, 0, 0);
    imem[11] = enc(3, 0, 1, 14);
    dmem[0] = 32'd5;
    dmem[1] = 32'd5;
    run_prog();
    chk("R6 flushed store 1", dmem[10], 32'd0);
    chk("R6 flushed store 2", dmem[11], 32'd0);
    chk("R6 not-taken falls through", dmem[12], 32'd5);
    chk("R10 jalr leaves reg", dmem[13], 32'd5);
    chk("R6 R8 cycles with branch", cycle_count, 32'd15);
    begin
      logic [31:0] held;
      held = cycle_count;
      repeat (8) @(negedge clk);
      chk("R7 counter frozen", cycle_count, held);
      chk("R7 still halted", 32'(halted), 32'd1);
      chk("R7 no store after halt", dmem[14], 32'd0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule